// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block returns a two-wire serial bus that a slave may have left stuck mid-byte to an idle state before normal traffic restarts. It drives the clock and data lines only through output-enable signals: asserting an enable pulls the line low, and releasing it lets the pull-up raise the line. The block never drives a high level. After a start pulse it releases both lines and clocks SCL a fixed number of times. On each pulse it samples SDA while SCL is high.

If SDA was high on any of those samples, the block checks that both lines read high, warning if they do not. It then makes a START and a STOP with SCL held high throughout, and waits out the bus-free time before it reports done. Because SCL never falls between the START and the STOP, a slave has no clock edge that could put it back into a stuck state. If SDA stayed low on every sample, the block skips the START/STOP step and reports failure. All delays are whole microseconds scaled by `CYCLES_PER_US`, and a single shared down-counter times every wait state.

States: `ST_IDLE`, `ST_RELEASE`, `ST_CLK_LO`, `ST_CLK_HI`, `ST_CHECK`, `ST_SETUP`, `ST_HOLD`, `ST_BUSFREE` and `ST_DONE`. The transitions are:

- `ST_IDLE`→`ST_RELEASE` on an accepted start pulse.
- `ST_RELEASE`→`ST_CLK_LO` when the timer expires.
- `ST_CLK_LO`→`ST_CLK_HI` when the timer expires.
- `ST_CLK_HI`→`ST_CLK_LO` when the timer expires and pulses remain.
- `ST_CLK_HI`→`ST_CHECK` after the last pulse if SDA was seen high.
- `ST_CLK_HI`→`ST_DONE` after the last pulse if SDA was never seen high.
- `ST_CHECK`→`ST_SETUP` after one cycle.
- `ST_SETUP`→`ST_HOLD`, `ST_HOLD`→`ST_BUSFREE` and `ST_BUSFREE`→`ST_DONE`, each when the timer expires.
- `ST_DONE`→`ST_IDLE` after one cycle.

Top module: `bus_unwedge`

## Requirements
- R1: After reset, `scl_oe_o`, `sda_oe_o`, `busy_o`, `done_o`, `fail_o` and `warn_o` are all 0. While the block is idle, both enables stay 0.
- R2: After an accepted start, both lines stay released for one phase of PHASE_US*CYCLES_PER_US cycles before the first pulse. `busy_o` is 1 from the cycle after the start through the cycle in which done is raised.
- R3: Exactly NUM_PULSES SCL pulses are generated (default 9). Each pulse is a low phase (`scl_oe_o`=1) followed by a high phase (`scl_oe_o`=0), and each phase lasts PHASE_US*CYCLES_PER_US cycles.
- R4: SDA is sampled only on the last cycle of each high phase. A high level on SDA during low phases does not count.
- R5: The SDA samples are ORed together, and all pulses are still generated after SDA has been seen high.
- R6: If no sample was high, `sda_oe_o` is never asserted, `fail_o` is 1 when done is raised, and no bus-free wait takes place.
- R7: If a sample was high, `warn_o` is set when SCL or SDA does not read high in the check cycle that follows the last pulse. The START/STOP step still runs.
- R8: START/STOP: `sda_oe_o` is asserted only while `scl_oe_o` is 0. `sda_oe_o` is preceded by exactly one phase, one check cycle and SETUP_US*CYCLES_PER_US cycles with both lines released, and it lasts exactly HOLD_US*CYCLES_PER_US cycles.
- R9: After SDA is released for the STOP, the bus stays idle for BUSFREE_US*CYCLES_PER_US cycles, and done is raised in the next cycle.
- R10: `done_o` is high for exactly one cycle. `fail_o` and `warn_o` hold their values until the next accepted start clears them.
- R11: A start pulse that arrives while the block is busy is ignored and has no effect on the pulse count or on done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin recovery (one-cycle pulse) |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | SDA never seen high during the clocking |
| warn_o | output | 1 | Lines not both high before the START |

## Verification
The bench targets the corner cases below:

- **Slave that releases SDA only during low phases.** A sampler that looked at the wrong phase would report success there instead of failure.
- **Slave that shows SDA high only on the first pulse.** A design that stopped clocking early would give fewer than nine pulses. A design that did not keep the OR sticky would report failure instead of a pins-not-at-rest warning.
- **Slave that shows SDA high only on the last pulse.** This catches an off-by-one in the pulse count.
- **Exact run lengths.** The bench measures the phase, setup, hold and bus-free lengths in cycles, so a miscounted shared timer load shows up as a length mismatch.
- **Start pulse during a run.** A second start mid-run must neither restart nor lengthen the sequence.

// File: rtl/unwedge_pkg.sv
package unwedge_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RELEASE,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_CHECK,
        ST_SETUP,
        ST_HOLD,
        ST_BUSFREE,
        ST_DONE
    } unwedge_state_t;
endpackage

// File: rtl/unwedge_timer.sv
module unwedge_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          zero_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/unwedge_ctrl.sv
module unwedge_ctrl
    import unwedge_pkg::*;
#(
    parameter int CW         = 8,
    parameter int NUM_PULSES = 9,
    parameter int PH_CYC     = 10,
    parameter int SU_CYC     = 2,
    parameter int HD_CYC     = 2,
    parameter int BF_CYC     = 60
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic          tmr_zero_i,
    output logic          tmr_load_o,
    output logic [CW-1:0] tmr_val_o,
    output logic          scl_oe_o,
    output logic          sda_oe_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          fail_o,
    output logic          warn_o
);
    localparam int PW = $clog2(NUM_PULSES + 1);
    localparam logic [CW-1:0] PH_LD = CW'(PH_CYC - 1);
    localparam logic [CW-1:0] SU_LD = CW'(SU_CYC - 1);
    localparam logic [CW-1:0] HD_LD = CW'(HD_CYC - 1);
    localparam logic [CW-1:0] BF_LD = CW'(BF_CYC - 1);
    localparam logic [PW-1:0] LAST_P = PW'(NUM_PULSES - 1);

    unwedge_state_t st_q, st_d;
    logic [PW-1:0]  pcnt_q;
    logic           seen_q, fail_q, warn_q;
    logic           seen_now, last_pulse, phase_end;

    assign seen_now   = seen_q | sda_i;
    assign last_pulse = (pcnt_q == LAST_P);
    assign phase_end  = (st_q == ST_CLK_HI) && tmr_zero_i;

    // state register and result flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            pcnt_q <= '0;
            seen_q <= 1'b0;
            fail_q <= 1'b0;
            warn_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && start_i) begin
                pcnt_q <= '0;
                seen_q <= 1'b0;
                fail_q <= 1'b0;
                warn_q <= 1'b0;
            end
            if (phase_end) begin
                seen_q <= seen_now;
                pcnt_q <= pcnt_q + 1'b1;
                if (last_pulse && !seen_now) fail_q <= 1'b1;
            end
            if (st_q == ST_CHECK) warn_q <= !(scl_i && sda_i);
        end
    end

    // next state and timer loads
    always_comb begin
        st_d       = st_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = PH_LD;
        unique case (st_q)
            ST_IDLE: if (start_i) begin
                st_d = ST_RELEASE; tmr_load_o = 1'b1; tmr_val_o = PH_LD;
            end
            ST_RELEASE: if (tmr_zero_i) begin
                st_d = ST_CLK_LO; tmr_load_o = 1'b1; tmr_val_o = PH_LD;
            end
            ST_CLK_LO: if (tmr_zero_i) begin
                st_d = ST_CLK_HI; tmr_load_o = 1'b1; tmr_val_o = PH_LD;
            end
            ST_CLK_HI: if (tmr_zero_i) begin
                if (!last_pulse) begin
                    st_d = ST_CLK_LO; tmr_load_o = 1'b1; tmr_val_o = PH_LD;
                end else if (seen_now) begin
                    st_d = ST_CHECK;
                end else begin
                    st_d = ST_DONE;
                end
            end
            ST_CHECK: begin
                st_d = ST_SETUP; tmr_load_o = 1'b1; tmr_val_o = SU_LD;
            end
            ST_SETUP: if (tmr_zero_i) begin
                st_d = ST_HOLD; tmr_load_o = 1'b1; tmr_val_o = HD_LD;
            end
            ST_HOLD: if (tmr_zero_i) begin
                st_d = ST_BUSFREE; tmr_load_o = 1'b1; tmr_val_o = BF_LD;
            end
            ST_BUSFREE: if (tmr_zero_i) st_d = ST_DONE;
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        scl_oe_o = (st_q == ST_CLK_LO);
        sda_oe_o = (st_q == ST_HOLD);
        busy_o   = (st_q != ST_IDLE);
        done_o   = (st_q == ST_DONE);
        fail_o   = fail_q;
        warn_o   = warn_q;
    end
endmodule

// File: rtl/bus_unwedge.sv
module bus_unwedge #(
    parameter int CYCLES_PER_US = 50,
    parameter int PHASE_US      = 5,
    parameter int SETUP_US      = 1,
    parameter int HOLD_US       = 1,
    parameter int BUSFREE_US    = 60,
    parameter int NUM_PULSES    = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_oe_o,
    output logic sda_oe_o,
    output logic busy_o,
    output logic done_o,
    output logic fail_o,
    output logic warn_o
);
    localparam int PH_CYC = PHASE_US * CYCLES_PER_US;
    localparam int SU_CYC = SETUP_US * CYCLES_PER_US;
    localparam int HD_CYC = HOLD_US * CYCLES_PER_US;
    localparam int BF_CYC = BUSFREE_US * CYCLES_PER_US;
    localparam int M1     = (PH_CYC > SU_CYC) ? PH_CYC : SU_CYC;
    localparam int M2     = (HD_CYC > BF_CYC) ? HD_CYC : BF_CYC;
    localparam int MAX_CYC = (M1 > M2) ? M1 : M2;
    localparam int CW     = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    logic          tmr_load, tmr_zero;
    logic [CW-1:0] tmr_val;

    unwedge_timer #(.CW(CW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    unwedge_ctrl #(
        .CW(CW), .NUM_PULSES(NUM_PULSES), .PH_CYC(PH_CYC),
        .SU_CYC(SU_CYC), .HD_CYC(HD_CYC), .BF_CYC(BF_CYC)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .tmr_zero_i (tmr_zero),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .scl_oe_o   (scl_oe_o),
        .sda_oe_o   (sda_oe_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .fail_o     (fail_o),
        .warn_o     (warn_o)
    );
endmodule

// File: rtl/unwedge_chk.sv
module unwedge_chk #(
    parameter int NUM_PULSES = 9
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic scl_oe_o,
    input logic sda_oe_o,
    input logic busy_o,
    input logic done_o,
    input logic fail_o
);
    localparam int KW = $clog2(NUM_PULSES + 2);
    logic [KW-1:0] rises_q;
    logic          scl_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rises_q    <= '0;
            scl_prev_q <= 1'b0;
        end else begin
            scl_prev_q <= scl_oe_o;
            if (!busy_o) rises_q <= '0;
            else if (scl_oe_o && !scl_prev_q && rises_q != '1) rises_q <= rises_q + 1'b1;
        end
    end

    p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!scl_oe_o && !sda_oe_o));
    p_pulse_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rises_q <= KW'(NUM_PULSES));
    p_no_stop_on_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> !fail_o);
    p_sda_while_scl_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> !scl_oe_o);
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_busy_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);
endmodule

bind bus_unwedge unwedge_chk #(.NUM_PULSES(NUM_PULSES)) u_unwedge_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .scl_oe_o (scl_oe_o),
    .sda_oe_o (sda_oe_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .fail_o   (fail_o)
);

// File: tb/bus_unwedge_bench.sv
`timescale 1ns/1ps
module bus_unwedge_bench;
    localparam int CPU = 4, PH_US = 2, SU_US = 1, HD_US = 1, BF_US = 60, NP = 9;
    localparam int P = PH_US * CPU, S = SU_US * CPU, H = HD_US * CPU, B = BF_US * CPU;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic scl_oe, sda_oe, busy, done, fail, warn;
    logic scl_line, sda_line, slave_sda;
    int   mode = 0, hi_pulse = 0;
    int   n_cmp = 0, n_bad = 0;
    bit   wd_hit = 0;

    // monitor state
    int  pulses, bad_phase, hold_len, setup_len, bf_len, gap, bf_cnt;
    int  done_cnt, multi_done, sda_rises, sda_viol;
    bit  prev_scl, prev_sda, prev_done, res_fail, res_warn;

    always #10 clk = ~clk;

    assign scl_line = !scl_oe;
    always_comb begin
        case (mode)
            0: slave_sda = 1'b1;
            1: slave_sda = 1'b0;
            2: slave_sda = (pulses == hi_pulse);
            default: slave_sda = !scl_line;
        endcase
    end
    assign sda_line = !sda_oe && slave_sda;

    bus_unwedge #(
        .CYCLES_PER_US(CPU), .PHASE_US(PH_US), .SETUP_US(SU_US),
        .HOLD_US(HD_US), .BUSFREE_US(BF_US), .NUM_PULSES(NP)
    ) u_bus_unwedge (
        .clk(clk), .rst_n(rst_n), .start_i(start), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy), .done_o(done),
        .fail_o(fail), .warn_o(warn)
    );

    int lo_run, hi_run;
    always @(negedge clk) begin
        if (scl_oe && !prev_scl) begin
            if (hi_run != P) bad_phase++;
            hi_run = 0;
            pulses++;
        end
        if (!scl_oe && prev_scl) begin
            if (lo_run != P) bad_phase++;
            lo_run = 0;
            gap = 1;
        end else if (!scl_oe && !sda_oe && busy && sda_rises == 0) gap++;
        if (scl_oe) lo_run++;
        else if (busy && !scl_oe && sda_rises == 0 && !sda_oe && pulses < NP) hi_run++;
        if (sda_oe && !prev_sda) begin sda_rises++; setup_len = gap; end
        if (sda_oe) hold_len++;
        if (sda_oe && scl_oe) sda_viol++;
        if (busy && !sda_oe && sda_rises > 0 && !done) bf_cnt++;
        if (done) begin
            done_cnt++;
            bf_len = bf_cnt;
            res_fail = fail;
            res_warn = warn;
            if (prev_done) multi_done++;
        end
        prev_scl = scl_oe; prev_sda = sda_oe; prev_done = done;
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        pulses = 0; bad_phase = 0; hold_len = 0; setup_len = 0; bf_len = 0; gap = 0;
        bf_cnt = 0; done_cnt = 0; multi_done = 0; sda_rises = 0; sda_viol = 0;
        lo_run = 0; hi_run = 0;
    endtask

    task automatic run_seq(input int m, input int k, input bit extra_start);
        mode = m; hi_pulse = k;
        clear_mon();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R2 busy after start", int'(busy), 1);
        if (extra_start) begin
            repeat (30) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
        end
        for (int i = 0; i < 5000 && done_cnt == 0; i++) @(negedge clk);
        repeat (20) @(negedge clk);
        check("R3 pulse count", pulses, NP);
        check("R3 R2 phase lengths", bad_phase, 0);
        check("R10 done once", done_cnt, 1);
        check("R10 done width", multi_done, 0);
        check("R1 idle after done", int'(busy | scl_oe | sda_oe), 0);
    endtask

    task automatic t_clean();
        run_seq(0, 0, 0);
        check("R6 fail clean", int'(res_fail), 0);
        check("R7 warn clean", int'(res_warn), 0);
        check("R8 setup length", setup_len, P + 1 + S);
        check("R8 hold length", hold_len, H);
        check("R8 sda only scl high", sda_viol, 0);
        check("R9 bus-free length", bf_len, B);
        check("R10 fail held", int'(fail), 0);
    endtask

    task automatic t_stuck();
        run_seq(1, 0, 0);
        check("R6 fail stuck", int'(res_fail), 1);
        check("R6 no sda drive", sda_rises, 0);
        check("R6 no bus-free", bf_len, 0);
        check("R10 fail held", int'(fail), 1);
    endtask

    task automatic t_low_phase_only();
        run_seq(3, 0, 0);
        check("R4 high in low phase ignored", int'(res_fail), 1);
        check("R4 no stop", sda_rises, 0);
    endtask

    task automatic t_first_only();
        run_seq(2, 1, 0);
        check("R5 sticky no fail", int'(res_fail), 0);
        check("R7 warn when sda low", int'(res_warn), 1);
        check("R7 stop still made", sda_rises, 1);
        check("R10 warn held", int'(warn), 1);
    endtask

    task automatic t_last_only();
        run_seq(2, NP, 0);
        check("R5 last sample counts", int'(res_fail), 0);
        check("R7 no warn", int'(res_warn), 0);
        check("R10 warn cleared by start", int'(warn), 0);
    endtask

    task automatic t_restart_ignored();
        run_seq(0, 0, 1);
        check("R11 stop count", sda_rises, 1);
        check("R11 bus-free length", bf_len, B);
    endtask

    initial begin
        clear_mon();
        prev_scl = 0; prev_sda = 0; prev_done = 0;
        repeat (3) @(negedge clk);
        check("R1 reset scl_oe", int'(scl_oe), 0);
        check("R1 reset sda_oe", int'(sda_oe), 0);
        check("R1 reset busy", int'(busy), 0);
        check("R1 reset done", int'(done), 0);
        check("R1 reset fail/warn", int'(fail | warn), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_clean();
        t_stuck();
        t_low_phase_only();
        t_first_only();
        t_last_only();
        t_restart_ignored();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        wd_hit = 1;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule